// File: doc/BRIEF.md
# Wavefront Permutation Arbiter

This block picks, once per cell time, a set of ingress-to-egress connections for a crossbar so that no ingress sends more than one cell and no egress receives more than one. It holds an N×N grid of queue counters, one for each (ingress row, egress column) pair. Each counter records how many cells wait in that virtual output queue. Request messages raise counters through a one-bit-per-queue increment mask. A start strobe launches a match pass. The pass ends with a match matrix that carries one bit per queue, and the queues that won are decremented.

The pass works like a diagonal wave. Every row begins in the seeking state and every column begins in the free state. The grid is walked one anti-diagonal per clock, starting at the top-left corner. A position wins when its row is still seeking, its column is still free and its queue is not empty. A win stops the row from seeking further right and stops the column from offering itself further down. Under light load the result may be a partial permutation. A build parameter can move the starting corner by one position after each pass, which spreads the precedence evenly.

Top module: `wavefront_arbiter`

## Requirements
- R1: After reset, `match` is all zero, `done` is low and every queue count is zero.
- R2: A `start` seen while no pass is running launches a pass. `done` is high for exactly one cycle, 2N−1 clock edges after the edge that sampled `start`. A `start` that arrives during a pass has no effect.
- R3: A position is granted only if its queue count is non-zero. A pass over an all-empty grid yields an all-zero `match`.
- R4: In every pass result, each ingress row (bits i*N .. i*N+N−1) and each egress column (bits j, j+N, ...) holds at most one set bit. Bit i*N+j stands for ingress i to egress j.
- R5: With the origin at (0,0), the result equals a greedy pass that takes rows 0 to N−1 in order. Each row takes its lowest-numbered free column with a non-empty queue. The position taken blocks the rest of its row and all of its column.
- R6: Every grant lowers that queue's count by one, so a queue loaded with k cells wins no more than k passes.
- R7: An increment that arrives while a pass runs does not affect that pass. It is added to the count once the pass ends.
- R8: A queue count saturates at 2^CNT_W−1. Further increments are lost.
- R9: `match` keeps its final value after `done` until the next accepted `start`, and it is cleared on the edge that accepts that start.
- R10: With ROTATE=1, the origin advances by one (mod N) after each pass. Row i and column j then rank as (i−origin) mod N and (j−origin) mod N in the precedence of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a match pass (ignored while one runs) |
| inc_mask | input | N_PORTS*N_PORTS | One added cell per set bit; bit i*N+j is queue ingress i to egress j |
| match | output | N_PORTS*N_PORTS | Grants of the last pass, same bit layout |
| done | output | 1 | One-cycle pulse when a pass ends |

## Verification
The assertions check four properties on every cycle. Each row and each column of `match` has at most one bit set. A counter drops by exactly one on a grant and holds steady otherwise while a pass runs. A saturated counter stays saturated. `done` never lasts longer than one cycle. Some behaviours appear only in the bench scenarios: the greedy precedence order, the exact pass length, the deferral of increments raised mid-pass and the rotated precedence. The bench shows these by comparing whole match matrices over a sequence of passes whose queue contents it tracks.

// File: rtl/wfa_pkg.sv
// Package wfa_pkg: shared types and helpers for the wavefront arbiter.
// Assumes every index handed to wrap_idx is below twice the modulus.
package wfa_pkg;

    // Phase of the pass sequencer.
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_SWEEP = 1'b1
    } phase_t;

    // Single-step modular reduction of an index in [0, 2n).
    function automatic int wrap_idx(input int x, input int n);
        return (x >= n) ? (x - n) : x;
    endfunction

endpackage

// File: rtl/wfa_seq.sv
// Module wfa_seq: steps a pass across the 2N-1 anti-diagonals, one per clock.
// It raises done for one cycle on the last step. When ROTATE is set it moves the
// precedence origin on by one after each pass.
// Assumes start is a level that is sampled only while idle.
module wfa_seq #(
    parameter int N      = 4,
    parameter bit ROTATE = 1'b0,
    parameter int DW     = $clog2(2 * N),
    parameter int IW     = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          launch,
    output logic          running,
    output logic [DW-1:0] diag,
    output logic [IW-1:0] origin,
    output logic          done
);
    import wfa_pkg::*;

    localparam logic [DW-1:0] LAST_DIAG  = DW'(2 * N - 2);
    localparam logic [IW-1:0] LAST_ORIGN = IW'(N - 1);

    phase_t phase;
    logic   final_step;

    assign running    = (phase == PH_SWEEP);
    assign launch     = start && (phase == PH_IDLE);
    assign final_step = running && (diag == LAST_DIAG);

    // Phase, diagonal counter and end-of-pass pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            diag  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                phase <= PH_SWEEP;
                diag  <= '0;
            end else if (final_step) begin
                phase <= PH_IDLE;
                done  <= 1'b1;
            end else if (running) begin
                diag <= diag + 1'b1;
            end
        end
    end

    generate
        if (ROTATE) begin : g_rotate
            // Advance the precedence origin at the end of every pass.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    origin <= '0;
                end else if (final_step) begin
                    origin <= (origin == LAST_ORIGN) ? '0 : origin + 1'b1;
                end
            end
        end else begin : g_fixed
            assign origin = '0;
        end
    endgenerate

    // R2: the end-of-pass flag never lasts two cycles.
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: the last diagonal step always produces done and returns to idle.
    assert_pass_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        final_step |=> (done && !running));

endmodule

// File: rtl/wfa_cell.sv
// Module wfa_cell: the cell counter of one virtual output queue.
// During a pass it only decrements on a grant, and increments wait in a pending
// counter. While idle, the pending and new increments are merged with saturation.
// Assumes grant is asserted only while running.
module wfa_cell #(
    parameter int CW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic inc,
    input  logic grant,
    output logic nonempty
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] count;
    logic [CW-1:0] pending;
    logic [CW:0]   merged;

    // Sum of the stored count, the deferred cells and this cycle's request.
    always_comb merged = {1'b0, count} + {1'b0, pending} + (CW + 1)'(inc);

    // Count and pending updates; the pass sees a frozen count apart from grants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            pending <= '0;
        end else if (running) begin
            count   <= count - CW'(grant);
            pending <= (pending == CMAX) ? CMAX : pending + CW'(inc);
        end else begin
            count   <= (merged > {1'b0, CMAX}) ? CMAX : merged[CW-1:0];
            pending <= '0;
        end
    end

    assign nonempty = (count != '0);

    // R6: a grant takes exactly one cell from the queue.
    assert_grant_decrement_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && grant) |=> (count == $past(count) - 1'b1));

    // R7: during a pass, requests never change the count.
    assert_pass_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !grant) |=> (count == $past(count)));

    // R8: a full queue stays full while no pass drains it.
    assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && (count == CMAX)) |=> (count == CMAX));

endmodule

// File: rtl/wfa_wave.sv
// Module wfa_wave: the grid logic of the wavefront. One seeking flag per row
// and one free flag per column pass along the current anti-diagonal. A grant
// clears both flags and is recorded in the match matrix.
// Assumes at most one grid position per row and per column lies on a diagonal.
module wfa_wave #(
    parameter int N  = 4,
    parameter int DW = 3,
    parameter int IW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           launch,
    input  logic           running,
    input  logic [DW-1:0]  diag,
    input  logic [IW-1:0]  origin,
    input  logic [N*N-1:0] nonempty,
    output logic [N*N-1:0] grant,
    output logic [N*N-1:0] match
);
    logic [N-1:0] seeking;
    logic [N-1:0] col_free;
    logic [N-1:0] row_take;
    logic [N-1:0] col_take;
    logic [N-1:0] col_grant [N];
    logic [N-1:0] col_match [N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_row
            for (genvar j = 0; j < N; j++) begin : g_col
                logic hit;
                // Grant when this position is on the active diagonal of the rotated grid.
                always_comb begin
                    int ra;
                    int cb;
                    ra  = wfa_pkg::wrap_idx(i + N - int'(origin), N);
                    cb  = wfa_pkg::wrap_idx(j + N - int'(origin), N);
                    hit = running && ((ra + cb) == int'(diag)) && seeking[i]
                          && col_free[j] && nonempty[i*N+j];
                end
                assign grant[i*N+j]   = hit;
                assign col_grant[j][i] = grant[i*N+j];
                assign col_match[j][i] = match[i*N+j];
            end
            assign row_take[i] = |grant[i*N +: N];
            assign col_take[i] = |col_grant[i];

            // R4: at most one winner per ingress row.
            assert_row_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(match[i*N +: N]));
            // R4: at most one winner per egress column.
            assert_col_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(col_match[i]));
        end
    endgenerate

    // Row and column flags: set at launch, cleared when the row or column wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seeking  <= '0;
            col_free <= '0;
        end else if (launch) begin
            seeking  <= '1;
            col_free <= '1;
        end else if (running) begin
            seeking  <= seeking & ~row_take;
            col_free <= col_free & ~col_take;
        end
    end

    // Match matrix: cleared on launch, collects grants, then holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match <= '0;
        end else if (launch) begin
            match <= '0;
        end else if (running) begin
            match <= match | grant;
        end
    end

endmodule

// File: rtl/wavefront_arbiter.sv
// Module wavefront_arbiter: top of the N x N wavefront permutation arbiter.
// It joins the pass sequencer, the grid logic and one counter per queue.
// Bit i*N_PORTS+j of inc_mask and match stands for ingress i to egress j.
// Assumes inc_mask bits are one-cycle requests, each adding one cell.
module wavefront_arbiter #(
    parameter int N_PORTS = 4,
    parameter int CNT_W   = 4,
    parameter bit ROTATE  = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [N_PORTS*N_PORTS-1:0]   inc_mask,
    output logic [N_PORTS*N_PORTS-1:0]   match,
    output logic                         done
);
    localparam int NQ = N_PORTS * N_PORTS;
    localparam int DW = $clog2(2 * N_PORTS);
    localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

    logic          launch;
    logic          running;
    logic [DW-1:0] diag;
    logic [IW-1:0] origin;
    logic [NQ-1:0] nonempty;
    logic [NQ-1:0] grant;

    wfa_seq #(.N(N_PORTS), .ROTATE(ROTATE), .DW(DW), .IW(IW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .launch  (launch),
        .running (running),
        .diag    (diag),
        .origin  (origin),
        .done    (done)
    );

    wfa_wave #(.N(N_PORTS), .DW(DW), .IW(IW)) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .running  (running),
        .diag     (diag),
        .origin   (origin),
        .nonempty (nonempty),
        .grant    (grant),
        .match    (match)
    );

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_queue
            wfa_cell #(.CW(CNT_W)) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .running  (running),
                .inc      (inc_mask[q]),
                .grant    (grant[q]),
                .nonempty (nonempty[q])
            );
        end
    endgenerate

endmodule

// File: tb/test_wavefront_arbiter.sv
module test_wavefront_arbiter;
    localparam int N          = 4;
    localparam int NQ         = N * N;
    localparam int CLK_PERIOD = 10;
    localparam int PASS_LEN   = 2 * N - 1;

    // Upper 16 bits: cells to add before the pass; lower 16: expected match.
    localparam logic [31:0] VECS [11] = '{
        32'h008E_0082, 32'h0000_0004, 32'h1F10_0218, 32'h8000_8100,
        32'h0001_0401, 32'h0000_1800, 32'h0000_0000, 32'hFFFF_8421,
        32'h0000_4812, 32'h0000_2184, 32'h0000_1248
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NQ-1:0] inc_mask = '0;
    logic [NQ-1:0] match;
    logic          done;
    logic          start_r = 1'b0;
    logic [NQ-1:0] inc_r = '0;
    logic [NQ-1:0] match_r;
    logic          done_r;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wavefront_arbiter #(.N_PORTS(N), .CNT_W(4), .ROTATE(1'b0)) i_wavefront_arbiter (
        .clk(clk), .rst_n(rst_n), .start(start), .inc_mask(inc_mask),
        .match(match), .done(done)
    );

    wavefront_arbiter #(.N_PORTS(N), .CNT_W(4), .ROTATE(1'b1)) i_rot (
        .clk(clk), .rst_n(rst_n), .start(start_r), .inc_mask(inc_r),
        .match(match_r), .done(done_r)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [NQ-1:0] m);
        @(negedge clk);
        inc_mask = m;
        @(negedge clk);
        inc_mask = '0;
    endtask

    task automatic run_pass(output int cyc);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic run_rot(output int cyc);
        @(negedge clk);
        start_r = 1'b1;
        @(negedge clk);
        start_r = 1'b0;
        cyc = 0;
        while (!done_r && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cyc;
        int done_hits;
        int done_at;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 match after reset", 32'(match), 32'h0);
        check("R1 done after reset", 32'(done), 32'h0);

        // Table walk: queue contents carry over from one vector to the next (R3, R4, R5, R6).
        foreach (VECS[k]) begin
            if (VECS[k][31:16] != 16'h0) load(VECS[k][31:16]);
            run_pass(cyc);
            if (k == 0) check("R2 pass length", 32'(cyc), 32'(PASS_LEN));
            check($sformatf("R5 vector %0d match", k), 32'(match), 32'(VECS[k][15:0]));
            @(negedge clk);
            if (k == 0) check("R2 done one cycle", 32'(done), 32'h0);
        end

        // R7: a request raised mid-pass stays out of the current pass.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        inc_mask = 16'h0001;
        @(negedge clk);
        inc_mask = '0;
        while (!done) @(negedge clk);
        check("R7 mid-pass request hidden", 32'(match), 32'h0);
        run_pass(cyc);
        check("R7 deferred request applied", 32'(match), 32'h0001);

        // R9: result held after done, cleared when the next start is accepted.
        repeat (5) @(negedge clk);
        check("R9 match held", 32'(match), 32'h0001);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 match cleared on start", 32'(match), 32'h0);
        while (!done) @(negedge clk);
        check("R3 empty grid gives no match", 32'(match), 32'h0);

        // R2: a second start during the pass is ignored.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        done_hits = 0;
        done_at = -1;
        for (int k = 0; k <= 13; k++) begin
            if (done) begin
                done_hits++;
                if (done_at < 0) done_at = k;
            end
            if (k == 2) start = 1'b1;
            if (k == 3) start = 1'b0;
            @(negedge clk);
        end
        check("R2 single done with restart attempt", 32'(done_hits), 32'd1);
        check("R2 done position", 32'(done_at), 32'(PASS_LEN));

        // R8: 20 requests to queue (1,1) saturate at 15 cells.
        @(negedge clk);
        inc_mask = 16'h0020;
        repeat (20) @(negedge clk);
        inc_mask = '0;
        for (int p = 0; p < 16; p++) begin
            run_pass(cyc);
            check($sformatf("R8 saturated drain pass %0d", p), 32'(match),
                  (p < 15) ? 32'h0020 : 32'h0);
        end

        // R10: rotating origin moves precedence from (0,0) to (0,1) on pass two.
        @(negedge clk);
        inc_r = 16'h0003;
        @(negedge clk);
        @(negedge clk);
        inc_r = '0;
        run_rot(cyc);
        check("R10 rotate pass at origin 0", 32'(match_r), 32'h0001);
        run_rot(cyc);
        check("R10 rotate pass at origin 1", 32'(match_r), 32'h0002);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule